// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 40-bit Accumulator

This block is a coprocessor-side datapath that multiplies two signed 32-bit register operands in one of six ways and adds the result into a private 40-bit accumulator. The core hands it an instruction word, the multiplicand and multiplier values it has already read, and a flag telling whether the instruction's condition passed. The block decodes the operation, runs an iterative multiplier and writes the accumulator when the multiply completes.

The multiplier retires one byte of the multiplier operand per cycle. It stops as soon as the bits still unread are only copies of the sign bit, so small multipliers finish in fewer cycles. A `busy` output covers the multiply, and a single-cycle `done` pulse marks the cycle in which the accumulator takes its new value. The accumulator can be read at any time and cleared with a synchronous input.

Top module: `mac40_unit`

## Requirements
- R1: After reset, `acc_out` is 0 and `busy`, `done` and `illegal` are all low.
- R2: Operation code 0000 in instruction bits 19:16 adds the signed product `opa`×`opb` (multiplicand × multiplier) to the accumulator, keeping the low 40 bits (the sum wraps modulo 2^40).
- R3: Operation codes 1100, 1101, 1110 and 1111 multiply one signed 16-bit half of each operand. Code bit 1 picks the half of `opa` and code bit 0 picks the half of `opb` (0 = bits 15:0, 1 = bits 31:16). The 32-bit product is sign-extended and added.
- R4: Operation code 1000 adds both signed products to the accumulator: `opa`[15:0]×`opb`[15:0] and `opa`[31:16]×`opb`[31:16].
- R5: A start with `cond_ok` low changes nothing. The accumulator keeps its value, and `busy` and `done` stay low.
- R6: A start with any other operation code, or with a nonzero accumulator select in instruction bits 7:5, gives a one-cycle `illegal` pulse in the following cycle. This happens whatever the value of `cond_ok`. `busy` stays low and the accumulator is unchanged.
- R7: The step count n is the smallest of 1 to 4 for which the multiplier (each used multiplier half, sign-extended, for the 16-bit codes, and the larger of the two for code 1000) is unchanged by sign extension from 8n bits. `busy` is high for the n cycles after the start edge. `done` pulses n cycles after the start edge, in the same cycle that `acc_out` shows the new value.
- R8: `start` is ignored while `busy` is high.
- R9: `acc_clear` zeroes the accumulator at the next edge. It takes priority over a write on the same edge.
- R10: Instruction bits outside 19:16 and 7:5 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the instruction held on `instr` |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Multiplicand operand |
| opb | input | 32 | Multiplier operand |
| cond_ok | input | 1 | Condition passed for this instruction |
| acc_clear | input | 1 | Synchronous accumulator clear |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse when the accumulator is written |
| illegal | output | 1 | One-cycle pulse for an undefined encoding |
| acc_out | output | 40 | Accumulator value |

## Verification
A legal start shows `busy` one cycle after its edge, and `done` together with the updated accumulator n cycles after it. The bench computes n from the multiplier's magnitude range and counts cycles until `done`, checking that count and the accumulator at that moment. An `illegal` pulse is due one cycle after the start and must be gone one cycle later. A failed-condition start or a clear is checked after the edge that would have changed the accumulator. All samples are taken on the falling clock edge.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

    parameter int DATA_W  = 32;
    parameter int ACC_W   = 40;
    parameter int STEP_W  = 8;
    parameter int HALF_W  = DATA_W / 2;
    parameter int STEPS   = DATA_W / STEP_W;
    parameter int CNT_W   = $clog2(STEPS + 1);
    parameter int OPF_LSB = 16;
    parameter int OPF_W   = 4;
    parameter int SEL_LSB = 5;
    parameter int SEL_W   = 3;

    typedef enum logic [OPF_W-1:0] {
        OP_FULL = 4'b0000,
        OP_DUAL = 4'b1000,
        OP_BB   = 4'b1100,
        OP_BT   = 4'b1101,
        OP_TB   = 4'b1110,
        OP_TT   = 4'b1111
    } mac_op_e;

    typedef struct packed {
        logic              legal;
        logic [DATA_W-1:0] mc0;
        logic [DATA_W-1:0] ml0;
        logic [DATA_W-1:0] mc1;
        logic [DATA_W-1:0] ml1;
        logic [CNT_W-1:0]  steps;
    } mac_job_t;

    function automatic logic [DATA_W-1:0] sext_half(logic [HALF_W-1:0] h);
        return {{(DATA_W-HALF_W){h[HALF_W-1]}}, h};
    endfunction

    // Fewest byte steps after which the unread multiplier bits are pure sign copies.
    function automatic logic [CNT_W-1:0] steps_needed(logic [DATA_W-1:0] v);
        logic [CNT_W-1:0]  res;
        logic [DATA_W-1:0] hi;
        res = CNT_W'(STEPS);
        for (int i = STEPS - 1; i >= 1; i--) begin
            hi = DATA_W'($signed(v) >>> (i * STEP_W - 1));
            if (hi == '0 || hi == '1) res = CNT_W'(i);
        end
        return res;
    endfunction

    // One byte step of a lane: the byte is signed only on the final step.
    function automatic logic [ACC_W-1:0] lane_term(logic [DATA_W-1:0] mc,
                                                   logic [DATA_W-1:0] ml,
                                                   int k, logic last);
        logic [STEP_W-1:0] b;
        logic [ACC_W-1:0]  mcx;
        logic [ACC_W-1:0]  bx;
        logic [ACC_W-1:0]  p;
        b   = STEP_W'(ml >> (k * STEP_W));
        mcx = {{(ACC_W-DATA_W){mc[DATA_W-1]}}, mc};
        bx  = {{(ACC_W-STEP_W){last & b[STEP_W-1]}}, b};
        p   = mcx * bx;
        return p << (k * STEP_W);
    endfunction

endpackage

// File: rtl/mac40_decode.sv
module mac40_decode
    import mac40_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output mac_job_t          job
);
    logic [OPF_W-1:0]  op;
    logic [SEL_W-1:0]  sel;
    logic [HALF_W-1:0] ha;
    logic [HALF_W-1:0] hb;
    logic [CNT_W-1:0]  n0;
    logic [CNT_W-1:0]  n1;

    assign op  = instr[OPF_LSB +: OPF_W];
    assign sel = instr[SEL_LSB +: SEL_W];
    assign ha  = op[1] ? opa[DATA_W-1:HALF_W] : opa[HALF_W-1:0];
    assign hb  = op[0] ? opb[DATA_W-1:HALF_W] : opb[HALF_W-1:0];

    always_comb begin
        job = '0;
        case (op)
            OP_FULL: begin
                job.legal = 1'b1;
                job.mc0   = opa;
                job.ml0   = opb;
            end
            OP_DUAL: begin
                job.legal = 1'b1;
                job.mc0   = sext_half(opa[HALF_W-1:0]);
                job.ml0   = sext_half(opb[HALF_W-1:0]);
                job.mc1   = sext_half(opa[DATA_W-1:HALF_W]);
                job.ml1   = sext_half(opb[DATA_W-1:HALF_W]);
            end
            OP_BB, OP_BT, OP_TB, OP_TT: begin
                job.legal = 1'b1;
                job.mc0   = sext_half(ha);
                job.ml0   = sext_half(hb);
            end
            default: job.legal = 1'b0;
        endcase
        if (sel != '0) job.legal = 1'b0;
        n0 = steps_needed(job.ml0);
        n1 = steps_needed(job.ml1);
        job.steps = (n0 > n1) ? n0 : n1;
    end
endmodule

// File: rtl/mac40_engine.sv
module mac40_engine
    import mac40_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  mac_job_t         job,
    output logic             busy,
    output logic             fin,
    output logic [ACC_W-1:0] product
);
    logic [DATA_W-1:0] mc0_q, ml0_q, mc1_q, ml1_q;
    logic [CNT_W-1:0]  steps_q;
    logic [CNT_W-1:0]  k_q;
    logic [ACC_W-1:0]  ps_q;
    logic              busy_q;
    logic              last;
    logic [ACC_W-1:0]  t0, t1;

    assign last    = (CNT_W'(k_q + 1'b1) == steps_q);
    assign t0      = lane_term(mc0_q, ml0_q, int'(k_q), last);
    assign t1      = lane_term(mc1_q, ml1_q, int'(k_q), last);
    assign product = ps_q + t0 + t1;
    assign fin     = busy_q & last;
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            k_q     <= '0;
            ps_q    <= '0;
            steps_q <= CNT_W'(1);
            mc0_q   <= '0;
            ml0_q   <= '0;
            mc1_q   <= '0;
            ml1_q   <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            k_q     <= '0;
            ps_q    <= '0;
            steps_q <= job.steps;
            mc0_q   <= job.mc0;
            ml0_q   <= job.ml0;
            mc1_q   <= job.mc1;
            ml1_q   <= job.ml1;
        end else if (busy_q) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                ps_q <= product;
                k_q  <= k_q + 1'b1;
            end
        end
    end

    // R7: step index stays inside the count chosen at issue
    p_step_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (k_q < steps_q) && (steps_q >= 1) && (steps_q <= CNT_W'(STEPS)));

    // R8: an unfinished multiply keeps running with its own step count
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> (busy_q && $stable(steps_q) && $stable(ml0_q)));
endmodule

// File: rtl/mac40_acc.sv
module mac40_acc
    import mac40_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (wr)    acc <= acc + addend;
    end

    // R5: without a write or clear the accumulator holds
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr && !clr) |=> $stable(acc));

    // R9: clear wins over a simultaneous write
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0));
endmodule

// File: rtl/mac40_unit.sv
module mac40_unit
    import mac40_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cond_ok,
    input  logic              acc_clear,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [ACC_W-1:0]  acc_out
);
    mac_job_t         job;
    logic             take;
    logic             load;
    logic             fin;
    logic [ACC_W-1:0] product;

    mac40_decode u_dec (
        .instr (instr),
        .opa   (opa),
        .opb   (opb),
        .job   (job)
    );

    assign take = start & ~busy;
    assign load = take & cond_ok & job.legal;

    mac40_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .job     (job),
        .busy    (busy),
        .fin     (fin),
        .product (product)
    );

    mac40_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (acc_clear),
        .wr     (fin),
        .addend (product),
        .acc    (acc_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= fin;
            illegal <= take & ~job.legal;
        end
    end

    // R7: a done pulse only ends a multiply that was running
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R7: done lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: an illegal start never launches a multiply
    p_illegal_idle_r6: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !done));
endmodule

// File: tb/sim_mac40_unit.sv
module sim_mac40_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] instr;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        cond_ok;
    logic        acc_clear;
    logic        busy;
    logic        done;
    logic        illegal;
    logic [39:0] acc_out;

    int checks = 0;
    int fails  = 0;
    logic [39:0] model_acc;

    always #5 clk = ~clk;

    mac40_unit u0 (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .opa(opa), .opb(opb),
        .cond_ok(cond_ok), .acc_clear(acc_clear), .busy(busy), .done(done),
        .illegal(illegal), .acc_out(acc_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bytes_for(input longint v);
        if (v >= -128 && v <= 127) return 1;
        if (v >= -32768 && v <= 32767) return 2;
        if (v >= -8388608 && v <= 8388607) return 3;
        return 4;
    endfunction

    function automatic logic [39:0] model_prod(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [3:0]  op;
        longint      p;
        logic [15:0] ha, hb;
        op = ins[19:16];
        ha = op[1] ? a[31:16] : a[15:0];
        hb = op[0] ? b[31:16] : b[15:0];
        if (op == 4'b0000)
            p = longint'($signed(a)) * longint'($signed(b));
        else if (op == 4'b1000)
            p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]))
              + longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
        else
            p = longint'($signed(ha)) * longint'($signed(hb));
        return p[39:0];
    endfunction

    function automatic int model_steps(input logic [31:0] ins, input logic [31:0] b);
        logic [3:0]  op;
        int          x, y;
        op = ins[19:16];
        if (op == 4'b0000) return bytes_for(longint'($signed(b)));
        if (op == 4'b1000) begin
            x = bytes_for(longint'($signed(b[15:0])));
            y = bytes_for(longint'($signed(b[31:16])));
            return (x > y) ? x : y;
        end
        return bytes_for(longint'($signed(op[0] ? b[31:16] : b[15:0])));
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [2:0] sel);
        logic [31:0] w;
        w = $urandom;          // R10: unrelated bits are random
        w[19:16] = op;
        w[7:5]   = sel;
        return w;
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        start = 1'b1; instr = ins; opa = a; opb = b; cond_ok = c;
        @(negedge clk);
        start = 1'b0; instr = $urandom; opa = $urandom; opb = $urandom; cond_ok = $urandom;
    endtask

    task automatic run_legal(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input string req);
        int n, cnt;
        n = model_steps(ins, b);
        model_acc = model_acc + model_prod(ins, a, b);
        issue(ins, a, b, 1'b1);
        chk(busy === 1'b1, "R7 busy after start", longint'(busy), 1);
        cnt = 0;
        while (done !== 1'b1 && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == n, "R7 cycles to done", cnt, n);
        chk(acc_out === model_acc, req, longint'(acc_out), longint'(model_acc));
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R7 done single pulse", longint'({done, busy}), 0);
    endtask

    task automatic run_illegal(input logic [31:0] ins, input logic c);
        issue(ins, $urandom, $urandom, c);
        chk(illegal === 1'b1 && busy === 1'b0, "R6 illegal pulse", longint'({illegal, busy}), 2);
        @(negedge clk);
        chk(illegal === 1'b0, "R6 pulse ends", longint'(illegal), 0);
        chk(acc_out === model_acc, "R6 acc unchanged", longint'(acc_out), longint'(model_acc));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [3:0] ops [6];
        ops = '{4'b0000, 4'b1000, 4'b1100, 4'b1101, 4'b1110, 4'b1111};
        void'($urandom(32'd5150));
        rst = 1'b1; start = 1'b0; instr = '0; opa = '0; opb = '0; cond_ok = 1'b0; acc_clear = 1'b0;
        model_acc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(acc_out === 40'd0 && busy === 1'b0 && done === 1'b0 && illegal === 1'b0,
            "R1 reset state", longint'(acc_out), 0);

        // R2 directed: wrap and extreme operands
        run_legal(mk(4'b0000, 3'd0), 32'h8000_0000, 32'h8000_0000, "R2 min*min");
        run_legal(mk(4'b0000, 3'd0), 32'h7fff_ffff, 32'h0000_0003, "R2 small multiplier");
        run_legal(mk(4'b0000, 3'd0), 32'h1234_5678, 32'hffff_ff80, "R2 negative one-byte");
        run_legal(mk(4'b0000, 3'd0), 32'hffff_ffff, 32'h0000_0080, "R2 two-byte positive");
        // R3 each halfword selection
        run_legal(mk(4'b1100, 3'd0), 32'h8000_7fff, 32'h8000_7fff, "R3 bottom x bottom");
        run_legal(mk(4'b1101, 3'd0), 32'h8000_7fff, 32'h8000_7fff, "R3 bottom x top");
        run_legal(mk(4'b1110, 3'd0), 32'h8000_7fff, 32'h8000_7fff, "R3 top x bottom");
        run_legal(mk(4'b1111, 3'd0), 32'h8000_7fff, 32'h8000_7fff, "R3 top x top");
        // R4 dual
        run_legal(mk(4'b1000, 3'd0), 32'h8000_8000, 32'h0005_8000, "R4 dual halves");

        // R5 failed condition
        issue(mk(4'b0000, 3'd0), 32'h0000_1000, 32'h0000_1000, 1'b0);
        chk(busy === 1'b0, "R5 no busy", longint'(busy), 0);
        repeat (5) begin
            @(negedge clk);
            chk(done === 1'b0 && acc_out === model_acc, "R5 acc kept", longint'(acc_out), longint'(model_acc));
        end

        // R6 undefined code and nonzero select
        run_illegal(mk(4'b0001, 3'd0), 1'b1);
        run_illegal(mk(4'b0000, 3'd1), 1'b1);
        run_illegal(mk(4'b1111, 3'd7), 1'b0);

        // R8 start while busy
        model_acc = model_acc + model_prod(mk(4'b0000, 3'd0), 32'h0000_0011, 32'h4000_0000);
        issue({12'h0, 4'b0000, 16'h0000}, 32'h0000_0011, 32'h4000_0000, 1'b1);
        start = 1'b1; instr = mk(4'b0001, 3'd0); opa = 32'h55; opb = 32'h66; cond_ok = 1'b1;
        @(negedge clk);
        chk(illegal === 1'b0, "R8 illegal start ignored while busy", longint'(illegal), 0);
        instr = mk(4'b0000, 3'd0);
        repeat (2) @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && busy === 1'b1, "R8 still busy at third cycle", longint'({done, busy}), 1);
        @(negedge clk);
        chk(done === 1'b1 && acc_out === model_acc, "R8 only first op counted", longint'(acc_out), longint'(model_acc));
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && acc_out === model_acc, "R8 no second op", longint'(acc_out), longint'(model_acc));

        // R9 clear colliding with a write
        issue(mk(4'b0000, 3'd0), 32'h0000_0100, 32'h0000_0002, 1'b1);
        acc_clear = 1'b1;
        @(negedge clk);
        acc_clear = 1'b0;
        chk(acc_out === 40'd0, "R9 clear beats write", longint'(acc_out), 0);
        model_acc = '0;

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  op;
            logic [31:0] a, b;
            op = ops[$urandom % 6];
            a  = $urandom;
            b  = 32'($signed($urandom) >>> ($urandom % 32));
            if (i % 3 == 0) b = {16'($signed($urandom) >>> ($urandom % 16)), 16'($signed($urandom) >>> ($urandom % 16))};
            run_legal(mk(op, 3'd0), a, b, "R2 R3 R4 R10 random");
        end
        summary();
    end
endmodule